// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between a host processor's parallel bus and the core of a character-display controller. A static strap input picks one of two bus styles. With the strap low, the host uses one enable strobe and a direction line. With the strap high, it uses separate active-low read and write strobes. A register-select line steers each write to the instruction path or the data path. A read returns either a status word or the core's data register.

All bus inputs are sampled into the controller clock through a two-flop synchronizer. The bus is assumed slow compared with the clock, so strobe edges are found by comparing two successive samples. The data path is 8 bits wide after reset. A function-set instruction written by the host can narrow it to 4 bits. In that mode every byte takes two transfers on data lines 7 to 4, and the upper half comes first. Each completed write reaches the core as a one-cycle pulse carrying the full byte and the select bit. Each completed data-register read produces a one-cycle acknowledge, which the core uses to prefetch the next location.

Top module: `hbus_if`

## Requirements
- R1: With `bus_mode` = 0, a write completes when `pin_b` (enable) falls while `pin_a` (direction) is 0. The byte on `pin_d` at that time is delivered as exactly one `core_wr` pulse.
- R2: With `bus_mode` = 1, a write completes on the rising edge of `pin_a`, which is then the active-low write strobe. The byte held on `pin_d` while the strobe was low is delivered as exactly one `core_wr` pulse.
- R3: `pin_oe` is high only during a read. With `bus_mode` = 0 that means `pin_b` is high while `pin_a` is 1. With `bus_mode` = 1 that means `pin_b` (active-low read strobe) is low. It follows the pins two clock edges after they are sampled.
- R4: In 8-bit mode a read with `pin_rs` = 0 drives `core_busy` on bit 7 and `core_addr` on bits 6..0. A read with `pin_rs` = 1 drives `core_dr`.
- R5: `core_wr_rs` carries the select bit of the write: 0 for the instruction register, 1 for the data register. `core_wr` is a single-cycle pulse registered on the third rising clock edge at which the ending strobe level is present on the pins.
- R6: In 4-bit mode a write uses only `pin_d[7:4]`. The first transfer gives the upper nibble and produces no pulse. The second gives the lower nibble and produces one pulse carrying the joined byte. `pin_d[3:0]` is ignored.
- R7: In 4-bit mode a read drives the upper nibble of the read word on `pin_dout[7:4]` first and the lower nibble second. `pin_dout[3:0]` is 0.
- R8: `core_rd_ack` pulses for one cycle when a read with `pin_rs` = 1 ends: after every such read in 8-bit mode, and after the second transfer in 4-bit mode. Status reads never produce it, and it never coincides with `core_wr`.
- R9: After reset the width is 8-bit. An instruction-register byte whose bits 7..5 are 001 sets the width from bit 4 (1 = 8-bit, 0 = 4-bit). Any width change returns the nibble sequence to the upper-nibble step.
- R10: While reset is held, `core_wr`, `core_rd_ack` and `pin_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | Strap: 0 = enable+direction, 1 = separate strobes |
| pin_a | input | 1 | Direction (mode 0) or active-low write strobe (mode 1) |
| pin_b | input | 1 | Enable (mode 0) or active-low read strobe (mode 1) |
| pin_rs | input | 1 | Register select |
| pin_d | input | 8 | Data bus input side |
| pin_dout | output | 8 | Data bus output side |
| pin_oe | output | 1 | Output enable for the data bus pads |
| core_busy | input | 1 | Busy flag from the core |
| core_addr | input | 7 | Address counter from the core |
| core_dr | input | 8 | Data register contents from the core |
| core_wr | output | 1 | One-cycle write pulse |
| core_wr_rs | output | 1 | Select bit of the write |
| core_wr_byte | output | 8 | Full written byte |
| core_rd_ack | output | 1 | One-cycle data-read acknowledge |

## Verification
The in-line assertions watch a few things on every cycle. The write and acknowledge pulses each last one cycle and never overlap. The nibble step stays at the upper half while the width is 8-bit. The width changes only in the cycle after a function-set byte was delivered. Other behaviour only shows up when whole host transactions are run through a behavioural model that the bench compares on every clock. That includes the nibble order of reads and writes, the status-word packing, which strap wiring produces which edge, and the switch between widths in both directions.

// File: rtl/hbus_pkg.sv
// Shared types and constants for the host bus interface.
package hbus_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int ADDR_W   = BYTE_W - 1;
    // Instruction byte family that carries the width bit.
    localparam logic [2:0] FSET_TAG = 3'b001;
    localparam int FSET_WBIT = 4;

    // One normalized sample of the host bus: strobes made active-high.
    typedef struct packed {
        logic              wr_a;
        logic              rd_a;
        logic              rs;
        logic [BYTE_W-1:0] d;
    } smp_t;
endpackage

// File: rtl/hbus_sync.sv
// Multi-stage synchronizer for the sampled bus, plus one history stage.
// Assumes the bus changes slowly, so all bits settle together.
module hbus_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [STAGES:0][W-1:0] chain;

    // Shift the sample chain; the last stage keeps one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i <= STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign cur  = chain[STAGES-1];
    assign prev = chain[STAGES];
endmodule

// File: rtl/hbus_edge.sv
// Finds the end of a write or read transfer from two successive samples.
// The data and select of the event come from the older sample, which was
// taken while the strobe was still active.
module hbus_edge
    import hbus_pkg::*;
(
    input  smp_t              cur,
    input  smp_t              prev,
    output logic              wr_ev,
    output logic              rd_ev,
    output logic              ev_rs,
    output logic [BYTE_W-1:0] ev_d
);
    // Falling edge of each normalized strobe marks the end of a transfer.
    always_comb begin
        wr_ev = prev.wr_a & ~cur.wr_a;
        rd_ev = prev.rd_a & ~cur.rd_a;
        ev_rs = prev.rs;
        ev_d  = prev.d;
    end
endmodule

// File: rtl/hbus_nibble.sv
// Width register, nibble sequencer and core-side pulse generation.
// Assumes write and read events never occur in the same cycle.
module hbus_nibble
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ev,
    input  logic              rd_ev,
    input  logic              ev_rs,
    input  logic [BYTE_W-1:0] ev_d,
    output logic              wr_pulse,
    output logic              wr_rs,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_ack,
    output logic              width8,
    output logic              lo_phase
);
    logic [NIB_W-1:0]  hi_q;
    logic [BYTE_W-1:0] byte_full;
    logic              emit;
    logic              fset;
    logic              new_w;

    // Join the stored upper nibble with the current one in 4-bit mode.
    always_comb begin
        byte_full = width8 ? ev_d : {hi_q, ev_d[BYTE_W-1:NIB_W]};
        emit      = wr_ev & (width8 | lo_phase);
        fset      = emit & ~ev_rs & (byte_full[BYTE_W-1:BYTE_W-3] == FSET_TAG);
        new_w     = byte_full[FSET_WBIT];
    end

    // Width, phase and held nibble state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width8   <= 1'b1;
            lo_phase <= 1'b0;
            hi_q     <= '0;
        end else begin
            if (fset && (new_w != width8)) begin
                width8   <= new_w;
                lo_phase <= 1'b0;
            end else if (!width8 && (wr_ev || rd_ev)) begin
                lo_phase <= ~lo_phase;
            end
            if (wr_ev && !width8 && !lo_phase) begin
                hi_q <= ev_d[BYTE_W-1:NIB_W];
            end
        end
    end

    // Registered one-cycle pulses toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pulse <= 1'b0;
            wr_rs    <= 1'b0;
            wr_byte  <= '0;
            rd_ack   <= 1'b0;
        end else begin
            wr_pulse <= emit;
            rd_ack   <= rd_ev & ev_rs & (width8 | lo_phase);
            if (emit) begin
                wr_rs   <= ev_rs;
                wr_byte <= byte_full;
            end
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pulse, rd_ack})); // R8
    AST_PHASE_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        width8 |-> !lo_phase); // R9
    AST_WIDTH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(width8) |-> (wr_pulse && !wr_rs
            && (wr_byte[BYTE_W-1:BYTE_W-3] == FSET_TAG))); // R9
endmodule

// File: rtl/hbus_if.sv
// Host bus interface top: normalizes the strapped bus style, synchronizes
// it, sequences nibbles and muxes the read word onto the data bus.
// Assumes bus_mode is static and strobes last several clock cycles.
module hbus_if
    import hbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_rs,
    input  logic [BYTE_W-1:0] pin_d,
    output logic [BYTE_W-1:0] pin_dout,
    output logic              pin_oe,
    input  logic              core_busy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [BYTE_W-1:0] core_dr,
    output logic              core_wr,
    output logic              core_wr_rs,
    output logic [BYTE_W-1:0] core_wr_byte,
    output logic              core_rd_ack
);
    localparam int SMP_W = $bits(smp_t);

    smp_t              raw_s, cur_s, prev_s;
    logic              wr_ev, rd_ev, ev_rs;
    logic [BYTE_W-1:0] ev_d;
    logic              width8, lo_phase;
    logic [BYTE_W-1:0] word;

    // Map the selected bus style onto active-high write/read strobes.
    always_comb begin
        raw_s.wr_a = bus_mode ? ~pin_a : (pin_b & ~pin_a);
        raw_s.rd_a = bus_mode ? ~pin_b : (pin_b &  pin_a);
        raw_s.rs   = pin_rs;
        raw_s.d    = pin_d;
    end

    hbus_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_s),
        .cur  (cur_s),
        .prev (prev_s)
    );

    hbus_edge u_edge (
        .cur  (cur_s),
        .prev (prev_s),
        .wr_ev(wr_ev),
        .rd_ev(rd_ev),
        .ev_rs(ev_rs),
        .ev_d (ev_d)
    );

    hbus_nibble u_nib (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ev   (wr_ev),
        .rd_ev   (rd_ev),
        .ev_rs   (ev_rs),
        .ev_d    (ev_d),
        .wr_pulse(core_wr),
        .wr_rs   (core_wr_rs),
        .wr_byte (core_wr_byte),
        .rd_ack  (core_rd_ack),
        .width8  (width8),
        .lo_phase(lo_phase)
    );

    // Read word selection and nibble placement on the upper lines.
    always_comb begin
        word = cur_s.rs ? core_dr : {core_busy, core_addr};
        if (width8)
            pin_dout = word;
        else if (lo_phase)
            pin_dout = {word[NIB_W-1:0], {NIB_W{1'b0}}};
        else
            pin_dout = {word[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
        pin_oe = cur_s.rd_a;
    end
endmodule

// File: tb/hbus_if_bench.sv
module hbus_if_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0;
    logic       pin_a = 1'b0, pin_b = 1'b0, pin_rs = 1'b0;
    logic [7:0] pin_d = 8'h00;
    logic [7:0] pin_dout;
    logic       pin_oe;
    logic       core_busy = 1'b0;
    logic [6:0] core_addr = 7'h00;
    logic [7:0] core_dr = 8'h00;
    logic       core_wr, core_wr_rs, core_rd_ack;
    logic [7:0] core_wr_byte;

    int n_chk = 0, n_err = 0;
    int n_wr = 0, n_ack = 0;
    logic [7:0] last_b = 8'h00;
    logic       last_rs = 1'b0;
    bit         done = 0;

    // reference model state
    bit         ha_w [4], ha_r [4], hrs [4];
    logic [7:0] hd [4];
    bit         m_w8 = 1, m_ph = 0, e_wr = 0, e_rs = 0, e_ack = 0, e_nib = 0;
    logic [3:0] m_hi = 4'h0;
    logic [7:0] e_byte = 8'h00;

    hbus_if u_hbus_if (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
        .pin_a(pin_a), .pin_b(pin_b), .pin_rs(pin_rs), .pin_d(pin_d),
        .pin_dout(pin_dout), .pin_oe(pin_oe),
        .core_busy(core_busy), .core_addr(core_addr), .core_dr(core_dr),
        .core_wr(core_wr), .core_wr_rs(core_wr_rs),
        .core_wr_byte(core_wr_byte), .core_rd_ack(core_rd_ack)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: host transactions seen through a sampling delay.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                ha_w[i] = 0; ha_r[i] = 0; hrs[i] = 0; hd[i] = 8'h00;
            end
            m_w8 = 1; m_ph = 0; m_hi = 4'h0; e_wr = 0; e_ack = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                ha_w[i] = ha_w[i-1]; ha_r[i] = ha_r[i-1];
                hrs[i] = hrs[i-1]; hd[i] = hd[i-1];
            end
            if (bus_mode) begin
                ha_w[0] = !pin_a; ha_r[0] = !pin_b;
            end else begin
                ha_w[0] = pin_b && !pin_a; ha_r[0] = pin_b && pin_a;
            end
            hrs[0] = pin_rs; hd[0] = pin_d;
            e_wr = 0; e_ack = 0;
            if (ha_w[3] && !ha_w[2]) begin
                e_nib = !m_w8;
                if (m_w8) begin
                    e_byte = hd[3]; e_wr = 1;
                end else if (!m_ph) begin
                    m_hi = hd[3][7:4]; m_ph = 1;
                end else begin
                    e_byte = {m_hi, hd[3][7:4]}; e_wr = 1; m_ph = 0;
                end
                if (e_wr) begin
                    e_rs = hrs[3];
                    if (!e_rs && e_byte[7:5] == 3'b001 && e_byte[4] != m_w8) begin
                        m_w8 = e_byte[4]; m_ph = 0;
                    end
                end
            end
            if (ha_r[3] && !ha_r[2]) begin
                if (m_w8) e_ack = hrs[3];
                else if (!m_ph) m_ph = 1;
                else begin m_ph = 0; e_ack = hrs[3]; end
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] w, ex;
            chk(core_wr == e_wr, bus_mode ? "R2 write pulse" : "R1 write pulse",
                {7'd0, core_wr}, {7'd0, e_wr});
            if (e_wr && core_wr) begin
                chk(core_wr_rs == e_rs, "R5 select", {7'd0, core_wr_rs}, {7'd0, e_rs});
                chk(core_wr_byte == e_byte, e_nib ? "R6 joined byte" : "R5 byte",
                    core_wr_byte, e_byte);
            end
            chk(core_rd_ack == e_ack, "R8 ack", {7'd0, core_rd_ack}, {7'd0, e_ack});
            chk(pin_oe == ha_r[1], "R3 oe", {7'd0, pin_oe}, {7'd0, ha_r[1]});
            if (pin_oe && ha_r[1]) begin
                w = hrs[1] ? core_dr : {core_busy, core_addr};
                ex = m_w8 ? w : (m_ph ? {w[3:0], 4'h0} : {w[7:4], 4'h0});
                chk(pin_dout == ex, m_w8 ? "R4 read word" : "R7 nibble read", pin_dout, ex);
            end
            if (core_wr) begin n_wr++; last_b = core_wr_byte; last_rs = core_wr_rs; end
            if (core_rd_ack) n_ack++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0;
        bus_mode = mode;
        pin_a = mode; pin_b = mode; pin_rs = 1'b0; pin_d = 8'h00;
        step(3);
        @(negedge clk);
        chk(!core_wr && !core_rd_ack && !pin_oe, "R10 reset outputs",
            {5'd0, core_wr, core_rd_ack, pin_oe}, 8'h00);
        step(1);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic hwr(input bit rs, input logic [7:0] d);
        pin_rs = rs; pin_d = d;
        if (bus_mode) begin
            step(1); pin_a = 1'b0; step(4); pin_a = 1'b1; step(6);
        end else begin
            pin_a = 1'b0; step(1); pin_b = 1'b1; step(4); pin_b = 1'b0; step(6);
        end
    endtask

    task automatic hrd(input bit rs);
        pin_rs = rs;
        if (bus_mode) begin
            step(1); pin_b = 1'b0; step(6); pin_b = 1'b1; step(6);
        end else begin
            pin_a = 1'b1; step(1); pin_b = 1'b1; step(6); pin_b = 1'b0; step(6);
        end
    endtask

    task automatic expect_last(input string tag, input int cnt0, input int ncnt,
                               input logic [7:0] b, input bit rs);
        chk(n_wr == cnt0 + ncnt, tag, n_wr[7:0], cnt0[7:0] + ncnt[7:0]);
        if (ncnt > 0) chk(last_b == b && last_rs == rs, tag, last_b, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, a0;
        // enable+direction style, 8-bit
        do_reset(1'b0);
        c0 = n_wr; hwr(1'b0, 8'h85); expect_last("R1 instr write", c0, 1, 8'h85, 1'b0);
        c0 = n_wr; hwr(1'b1, 8'h41); expect_last("R5 data write", c0, 1, 8'h41, 1'b1);
        core_busy = 1'b1; core_addr = 7'h25; hrd(1'b0);
        core_busy = 1'b0; core_addr = 7'h5A; hrd(1'b0);
        core_dr = 8'hA5; a0 = n_ack; hrd(1'b1);
        chk(n_ack == a0 + 1, "R8 ack per 8-bit data read", n_ack[7:0], a0[7:0] + 8'd1);
        a0 = n_ack; hrd(1'b0);
        chk(n_ack == a0, "R8 no ack on status read", n_ack[7:0], a0[7:0]);
        // same-width function set keeps 8-bit
        c0 = n_wr; hwr(1'b0, 8'h38); hwr(1'b1, 8'h66);
        expect_last("R9 stays 8-bit", c0, 2, 8'h66, 1'b1);
        // switch to 4-bit
        c0 = n_wr; hwr(1'b0, 8'h20); expect_last("R9 fset to 4-bit", c0, 1, 8'h20, 1'b0);
        c0 = n_wr; hwr(1'b1, 8'h4F);
        expect_last("R6 no pulse after upper nibble", c0, 0, 8'h00, 1'b0);
        hwr(1'b1, 8'h1C); expect_last("R6 joined byte", c0, 1, 8'h41, 1'b1);
        core_dr = 8'h3C; a0 = n_ack; hrd(1'b1);
        chk(n_ack == a0, "R8 no ack after first nibble", n_ack[7:0], a0[7:0]);
        hrd(1'b1);
        chk(n_ack == a0 + 1, "R8 ack after second nibble", n_ack[7:0], a0[7:0] + 8'd1);
        core_busy = 1'b1; core_addr = 7'h13; hrd(1'b0); hrd(1'b0);
        // back to 8-bit through two nibbles
        c0 = n_wr; hwr(1'b0, 8'h3A); hwr(1'b0, 8'h05);
        expect_last("R9 fset to 8-bit", c0, 1, 8'h30, 1'b0);
        c0 = n_wr; hwr(1'b1, 8'h77); expect_last("R9 8-bit again", c0, 1, 8'h77, 1'b1);

        // separate-strobe style
        do_reset(1'b1);
        c0 = n_wr; hwr(1'b0, 8'h9C); expect_last("R2 instr write", c0, 1, 8'h9C, 1'b0);
        c0 = n_wr; hwr(1'b1, 8'hE3); expect_last("R2 data write", c0, 1, 8'hE3, 1'b1);
        core_busy = 1'b0; core_addr = 7'h7F; hrd(1'b0);
        core_dr = 8'h96; a0 = n_ack; hrd(1'b1);
        chk(n_ack == a0 + 1, "R8 ack strobe style", n_ack[7:0], a0[7:0] + 8'd1);
        c0 = n_wr; hwr(1'b0, 8'h2C); expect_last("R9 fset 4-bit", c0, 1, 8'h2C, 1'b0);
        c0 = n_wr; hwr(1'b1, 8'hD0); hwr(1'b1, 8'hB7);
        expect_last("R6 joined byte strobe style", c0, 1, 8'hDB, 1'b1);
        core_busy = 1'b1; core_addr = 7'h42; hrd(1'b0); hrd(1'b0);
        core_dr = 8'h5E; hrd(1'b1); hrd(1'b1);
        // reset returns to 8-bit
        do_reset(1'b1);
        c0 = n_wr; hwr(1'b1, 8'h12); expect_last("R9 reset width 8-bit", c0, 1, 8'h12, 1'b1);

        step(4);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule